// File: doc/BRIEF.md
# Rising-Edge Pulse Detector with Moore and Mealy Outputs

This block watches a vector of synchronous single-bit signals and flags every 0-to-1 transition on each of them. Each lane runs two detectors side by side that see the same input and report the same event with different timing.

The first detector is a three-state Moore machine. Its pulse comes from a flip-flop, starts at the clock edge that samples the new 1, and lasts exactly one clock period. The second detector is a one-flip-flop Mealy machine. Its pulse is combinational: it rises as soon as the input rises, while the stored sample is still 0, and it falls at the edge that samples the 1. Because of this, the Mealy pulse can be shorter than a period. It can also appear for a high level that no clock edge ever samples.

The lanes are independent. The block is meant for inputs that are already synchronous to `clk`.

Top module: `rise_pulse_dual`

## Requirements
- R1: While `rst` is high, both machines are forced to the zero state at each rising clock edge. `out_mealy` is 0 combinationally while `rst` is high, and `out_moore` is 0 in the cycle after any edge that samples `rst` high.
- R2: For a lane, when an edge samples `in` = 1 and the previous non-reset edge sampled 0, `out_moore` of that lane is 1 for exactly the following clock period.
- R3: While a lane's input stays 1 over successive edges, that lane's `out_moore` gives only the first one-period pulse and is never 1 in two consecutive cycles.
- R4: `out_mealy` of a lane equals `in` AND NOT the lane's last sampled input, at any time outside reset. A rising input therefore raises `out_mealy` in the same cycle, before any clock edge.
- R5: `out_mealy` of a lane returns to 0 at the clock edge that samples the lane's input as 1, even while the input stays high.
- R6: A high level that rises and falls between two clock edges produces an `out_mealy` pulse and no `out_moore` pulse.
- R7: Each bit of `in` drives only the same bit of `out_moore` and `out_mealy`; lanes with different patterns do not affect each other.
- R8: An input held at 1 while `rst` is released counts as a rising edge. `out_mealy` is 1 in the first cycle after reset, and `out_moore` is 1 in the cycle after the first non-reset edge.
- R9: An input that alternates every cycle produces one `out_moore` pulse for each sampled rise, which means a pulse in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in | input | LANES | Synchronous input bits to watch |
| out_moore | output | LANES | Registered one-period rise pulse per lane |
| out_mealy | output | LANES | Combinational rise pulse per lane |

## Verification
The hardest case to reach is a high level that lives only between two clock edges. No edge samples it, so the Moore output must stay quiet while the Mealy output still pulses. The bench raises and lowers the input within one low clock phase. It checks the Mealy output inside that window, and then checks that the Moore output stays 0 across the following edges. A second case that is easy to miss is an input held high across the release of reset. The bench drives that condition before deasserting reset and checks both outputs at the first two edges after it.

// File: rtl/rise_pulse_pkg.sv
package rise_pulse_pkg;

  // Moore state encoding: bit 0 follows the input, bit 1 marks "already reported"
  typedef enum logic [1:0] {
    ST_ZERO   = 2'b00,
    ST_CHANGE = 2'b01,
    ST_ONE    = 2'b11
  } moore_st_t;

  // Next-state equations of the Moore machine
  function automatic logic [1:0] moore_next(input logic din, input logic [1:0] ps);
    return {din & ps[0], din};
  endfunction

  // Moore output decode: high only in the "just changed" state
  function automatic logic moore_decode(input logic [1:0] st);
    return ~st[1] & st[0];
  endfunction

endpackage

// File: rtl/edge_moore_fsm.sv
module edge_moore_fsm
  import rise_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pulse
);

  logic [1:0] ps_q;
  logic [1:0] ns;
  logic       pulse_q;

  always_comb begin
    ns = moore_next(din, ps_q);
  end

  // Output flop loaded with the decode of the state being entered,
  // so it always matches the decode of ps_q without a gate after the register
  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q    <= ST_ZERO;
      pulse_q <= 1'b0;
    end else begin
      ps_q    <= ns;
      pulse_q <= moore_decode(ns);
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/edge_mealy_fsm.sv
module edge_mealy_fsm (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pulse
);

  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= din;
  end

  // Combinational by nature; gated so it stays low during reset
  assign pulse = din & ~seen_q & ~rst;

endmodule

// File: rtl/rise_pulse_dual.sv
module rise_pulse_dual #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] in,
  output logic [LANES-1:0] out_moore,
  output logic [LANES-1:0] out_mealy
);

  localparam int LastLane = LANES - 1;

  for (genvar g = 0; g <= LastLane; g++) begin : g_lane
    edge_moore_fsm u_moore (
      .clk   (clk),
      .rst   (rst),
      .din   (in[g]),
      .pulse (out_moore[g])
    );

    edge_mealy_fsm u_mealy (
      .clk   (clk),
      .rst   (rst),
      .din   (in[g]),
      .pulse (out_mealy[g])
    );
  end

endmodule

// File: rtl/rise_pulse_dual_chk.sv
module rise_pulse_dual_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] in,
  input logic [LANES-1:0] out_moore,
  input logic [LANES-1:0] out_mealy
);

  logic [LANES-1:0] smp_q;
  logic             live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      live_q <= 1'b0;
    end else begin
      smp_q  <= in;
      live_q <= 1'b1;
    end
  end

  // R1: mealy output is low whenever reset is high
  always_comb begin
    if (rst) assert_mealy_quiet_in_reset_R1: assert (out_mealy == '0);
  end

  // R1: first cycle after a reset edge has no moore pulse
  assert_moore_low_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    !live_q |-> out_moore == '0);

  // R2: moore pulse follows a sampled rise by exactly one edge
  assert_moore_follows_rise_R2: assert property (@(posedge clk) disable iff (rst)
    live_q |-> out_moore == ($past(in) & ~$past(smp_q)));

  // R3: never two consecutive moore cycles on a lane
  assert_moore_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (out_moore & $past(out_moore)) == '0);

  // R4: mealy output tracks input against last sample
  assert_mealy_combo_R4: assert property (@(posedge clk) disable iff (rst)
    out_mealy == (in & ~smp_q));

endmodule

bind rise_pulse_dual rise_pulse_dual_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in        (in),
  .out_moore (out_moore),
  .out_mealy (out_mealy)
);

// File: tb/tb_rise_pulse_dual.sv
module tb_rise_pulse_dual;

  localparam int LANES = 4;
  localparam int MAX_CYCLES = 200000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LANES-1:0] din = '0;
  logic [LANES-1:0] out_moore;
  logic [LANES-1:0] out_mealy;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  rise_pulse_dual #(.LANES(LANES)) dut (
    .clk       (clk),
    .rst       (rst),
    .in        (din),
    .out_moore (out_moore),
    .out_mealy (out_mealy)
  );

  always #5 clk = ~clk;

  // Reference model from the requirements
  logic [LANES-1:0] m_prev = '0;
  logic [LANES-1:0] m_moore = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_prev  <= '0;
      m_moore <= '0;
    end else begin
      m_moore <= din & ~m_prev;
      m_prev  <= din;
    end
  end

  function automatic logic [LANES-1:0] exp_mealy();
    return rst ? '0 : (din & ~m_prev);
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (out_moore !== m_moore || out_mealy !== exp_mealy()) begin
      n_fails++;
      $display("FAIL %s t=%0t moore=%b exp=%b mealy=%b exp=%b",
               tag, $time, out_moore, m_moore, out_mealy, exp_mealy());
    end
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check shortly after
  task automatic step(input logic r, input logic [LANES-1:0] v, input string tag);
    @(negedge clk);
    rst = r;
    din = v;
    #1 check(tag);
  endtask

  task automatic t_reset_r1();
    step(1'b1, '1, "R1 reset in high");
    step(1'b1, '1, "R1 reset held");
    check_val("R1 mealy low in reset", int'(out_mealy), 0);
    check_val("R1 moore low in reset", int'(out_moore), 0);
    step(1'b1, '0, "R1 reset in low");
    step(1'b0, '0, "R1 released");
  endtask

  task automatic t_single_r2_r5();
    int hi = 0;
    step(1'b0, 4'b0001, "R4 mealy rises same cycle");
    check_val("R4 mealy lane0 before edge", int'(out_mealy[0]), 1);
    check_val("R2 moore not yet", int'(out_moore[0]), 0);
    step(1'b0, 4'b0001, "R5 mealy falls after edge");
    check_val("R5 mealy low", int'(out_mealy[0]), 0);
    check_val("R2 moore high", int'(out_moore[0]), 1);
    hi = 1;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 4'b0001, "R3 held high");
      hi += int'(out_moore[0]);
    end
    check_val("R3 one moore pulse while held", hi, 1);
    step(1'b0, '0, "R2 fall");
    step(1'b0, '0, "R2 idle");
  endtask

  task automatic t_toggle_r9();
    int hi = 0;
    for (int i = 0; i < 8; i++) begin
      step(1'b0, (i % 2 == 0) ? 4'b0010 : 4'b0000, "R9 toggle");
      hi += int'(out_moore[1]);
    end
    step(1'b0, '0, "R9 tail");
    hi += int'(out_moore[1]);
    check_val("R9 pulses per rise", hi, 4);
  endtask

  task automatic t_glitch_r6();
    int hi = 0;
    @(negedge clk);
    rst = 1'b0;
    din = 4'b0100;
    #1 check("R6 glitch high");
    check_val("R6 mealy during glitch", int'(out_mealy[2]), 1);
    #2 din = '0;
    #1 check("R6 glitch low");
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, "R6 after glitch");
      hi += int'(out_moore[2]);
    end
    check_val("R6 no moore pulse", hi, 0);
  endtask

  task automatic t_lanes_r7();
    logic [LANES-1:0] pat [6] = '{4'b0101, 4'b0111, 4'b1010, 4'b1011, 4'b0001, 4'b1100};
    for (int i = 0; i < 6; i++) step(1'b0, pat[i], "R7 mixed lanes");
    step(1'b0, '0, "R7 clear");
  endtask

  task automatic t_reset_high_r8();
    step(1'b1, '1, "R8 reset with in high");
    step(1'b1, '1, "R8 reset with in high 2");
    step(1'b0, '1, "R8 release in high");
    check_val("R8 mealy after release", int'(out_mealy), 15);
    check_val("R8 moore not yet", int'(out_moore), 0);
    step(1'b0, '1, "R8 next cycle");
    check_val("R8 moore pulse", int'(out_moore), 15);
    check_val("R8 mealy dropped", int'(out_mealy), 0);
    step(1'b1, '1, "R1 reset mid pulse");
    step(1'b0, '0, "R1 after reset");
    check_val("R1 moore cleared", int'(out_moore), 0);
  endtask

  initial begin
    t_reset_r1();
    t_single_r2_r5();
    t_toggle_r9();
    t_glitch_r6();
    t_lanes_r7();
    t_reset_high_r8();
    step(1'b0, '0, "final");
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", MAX_CYCLES);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule